// File: doc/BRIEF.md
# I2C Start/Stop Condition Detector

This block watches the two wires of an I2C bus and reports bus START and STOP conditions. Each wire passes through a two-flop synchronizer first. A transition on SDA is accepted as a condition only when SCL was already high for a programmed number of counting ticks before the transition. SCL must then stay high, and SDA must keep its new level, for the same number of ticks afterwards. Ticks come from a clock-enable input, `tick_en`. That input carries the divided system clock, so one setting gives a real-time window that depends on the divide ratio. A detected START sets a bus-busy flag and a detected STOP clears it.

The block also holds an edge interrupt source. One control bit selects whether SCL or SDA is watched. A second control bit selects whether the rising or the falling edge of that wire raises the request. The request is sticky until software clears it. A change of either control bit, or of the interface enable, can itself raise a request. Software should therefore clear the request after it reconfigures the source.

The control register is written as a whole byte. The window setting is 5 bits wide and must be even and non-zero. An illegal value is refused: the window keeps its old value and a reject flag is raised.

Top module: `i2c_cond_detector`

## Requirements
- R1: After reset, `start_det`, `stop_det`, `bus_busy`, `irq_req` and `cfg_reject` are all 0, and both synchronized wires read as idle-high.
- R2: An SDA fall while SCL is high counts as a START when SCL had been high for at least W ticks (W = control bits [4:0]) and SCL and SDA then hold their levels for W ticks. It produces exactly one single-cycle `start_det` pulse, and `bus_busy` reads 1 afterwards.
- R3: An SDA rise under the same setup and hold qualification gives exactly one single-cycle `stop_det` pulse, and `bus_busy` reads 0 afterwards.
- R4: An SDA transition that comes fewer than W ticks after SCL went high produces no detect pulse and leaves `bus_busy` unchanged.
- R5: When SCL falls fewer than W ticks after a qualifying SDA transition, no detect pulse is produced.
- R6: A register write whose bits [4:0] are zero or odd leaves W unchanged and sets `cfg_reject` to 1. A write with a legal value updates W and clears `cfg_reject`.
- R7: The setup and hold counts advance only in cycles where `tick_en` is 1.
- R8: With control bit 6 = 0 (watch SCL) and bit 5 = 0 (falling edge), an SCL fall sets `irq_req`. SDA edges do not set it.
- R9: With bit 6 = 1 (watch SDA) and bit 5 = 1 (rising edge), an SDA rise sets `irq_req`. An SDA fall does not set it.
- R10: `irq_req` stays 1 until `irq_clr` is pulsed. After the pulse it reads 0.
- R11: With `iface_en` = 0, pin edges do not set `irq_req`. While the interface is enabled, changing the polarity bit so that the watched wire already matches the selected level sets `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Divided-clock enable; counting happens only when high |
| iface_en | input | 1 | Interface enable for the edge interrupt source |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control data: [4:0] window W, [5] rising-edge select, [6] watch SDA |
| irq_clr | input | 1 | Clears the interrupt request |
| start_det | output | 1 | One-cycle START detect pulse |
| stop_det | output | 1 | One-cycle STOP detect pulse |
| bus_busy | output | 1 | High between a detected START and a detected STOP |
| irq_req | output | 1 | Sticky edge interrupt request |
| cfg_reject | output | 1 | The last control write carried an illegal window |

## Verification
The hardest situation to reach is the one where the divided tick stretches the windows. With `tick_en` pulsed only every fourth cycle, a setup that would qualify at full rate must be rejected. The stimulus repeats a condition that passed at full rate under the sparse tick, then lengthens it until it passes again. The spurious reconfiguration request is also hard to reach: it is produced by setting the watched wire to a level, then rewriting only the polarity bit while no wire moves.

// File: rtl/i2c_cond_pkg.sv
// Package: shared widths and the control register layout for the
// start/stop condition detector.
package i2c_cond_pkg;
    parameter int WIN_W = 5;

    // Kind of condition held while its hold window is counted
    typedef enum logic {
        EV_START = 1'b0,
        EV_STOP  = 1'b1
    } cond_kind_e;

    // Decoded control register contents
    typedef struct packed {
        logic             sel_sda;
        logic             pol_rise;
        logic [WIN_W-1:0] win;
    } cond_ctrl_t;
endpackage

// File: rtl/cond_sync.sv
// Module: cond_sync
// Brings WIDTH asynchronous wire levels into the clock domain through
// STAGES flops each. Assumes the wires idle high, so reset loads ones.
module cond_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            // shift the wire level through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_in[g]};
            end
            assign d_out[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cond_qualifier.sv
// Module: cond_qualifier
// Qualifies SDA transitions under a high SCL against a setup and a hold
// window of `win` ticks and tracks the bus-busy state. Assumes win is
// even and non-zero (the register stage refuses other values).
module cond_qualifier
    import i2c_cond_pkg::*;
#(
    parameter int CW = WIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic [CW-1:0] win,
    output logic          start_det,
    output logic          stop_det,
    output logic          bus_busy
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic          sda_d;
    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] hold_cnt;
    logic          armed;
    cond_kind_e    kind;
    logic          sda_fall, sda_rise;
    logic [CW:0]   hold_next;

    assign sda_fall  = sda_d & ~sda_s;
    assign sda_rise  = ~sda_d & sda_s;
    assign hold_next = {1'b0, hold_cnt} + 1'b1;

    // remember the previous synchronized SDA level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sda_d <= 1'b1;
        else        sda_d <= sda_s;
    end

    // count ticks of continuous SCL high time, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                          hi_cnt <= '0;
        else if (!scl_s)                     hi_cnt <= '0;
        else if (tick_en && hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
    end

    // arm on a qualified SDA edge, then count the hold window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            kind      <= EV_START;
            hold_cnt  <= '0;
            start_det <= 1'b0;
            stop_det  <= 1'b0;
        end else begin
            start_det <= 1'b0;
            stop_det  <= 1'b0;
            if (!armed) begin
                if (scl_s && (sda_fall || sda_rise) && hi_cnt >= win) begin
                    armed    <= 1'b1;
                    kind     <= sda_rise ? EV_STOP : EV_START;
                    hold_cnt <= '0;
                end
            end else if (!scl_s || (sda_s != (kind == EV_STOP))) begin
                armed <= 1'b0;
            end else if (tick_en) begin
                if (hold_next >= {1'b0, win}) begin
                    armed <= 1'b0;
                    if (kind == EV_STOP) stop_det  <= 1'b1;
                    else                 start_det <= 1'b1;
                end else begin
                    hold_cnt <= hold_next[CW-1:0];
                end
            end
        end
    end

    // bus busy from START until STOP
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_busy <= 1'b0;
        else if (start_det) bus_busy <= 1'b1;
        else if (stop_det)  bus_busy <= 1'b0;
    end
endmodule

// File: rtl/cond_edge_irq.sv
// Module: cond_edge_irq
// Sticky interrupt on a chosen edge of SCL or SDA. The watched level is
// formed after pin and polarity selection, so reconfiguration can itself
// produce an edge; software clears the request afterwards.
module cond_edge_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_s,
    input  logic sda_s,
    input  logic sel_sda,
    input  logic pol_rise,
    input  logic clr,
    output logic irq_req
);
    logic lvl, lvl_d;

    assign lvl = en & ((sel_sda ? sda_s : scl_s) ~^ pol_rise);

    // track previous watched level and hold the request until cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d   <= 1'b0;
            irq_req <= 1'b0;
        end else begin
            lvl_d <= lvl;
            if (lvl && !lvl_d) irq_req <= 1'b1;
            else if (clr)      irq_req <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_cond_detector.sv
// Module: i2c_cond_detector (top)
// Control register with illegal-window refusal, wire synchronizer,
// start/stop qualifier and edge interrupt source. Assumes tick_en is
// the divided system clock enable.
module i2c_cond_detector
    import i2c_cond_pkg::*;
#(
    parameter int             SYNC_STAGES = 2,
    parameter logic [WIN_W-1:0] RST_WIN   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       iface_en,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       irq_clr,
    output logic       start_det,
    output logic       stop_det,
    output logic       bus_busy,
    output logic       irq_req,
    output logic       cfg_reject
);
    cond_ctrl_t       ctrl;
    logic [1:0]       wires_s;
    logic [WIN_W-1:0] new_win;
    logic             win_bad;

    assign new_win = reg_wdata[WIN_W-1:0];
    assign win_bad = (new_win == '0) || new_win[0];

    // control register; an illegal window is refused and flagged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '{sel_sda: 1'b0, pol_rise: 1'b0, win: RST_WIN};
            cfg_reject <= 1'b0;
        end else if (reg_wr) begin
            ctrl.pol_rise <= reg_wdata[5];
            ctrl.sel_sda  <= reg_wdata[6];
            cfg_reject    <= win_bad;
            if (!win_bad) ctrl.win <= new_win;
        end
    end

    cond_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sda_in, scl_in}),
        .d_out (wires_s)
    );

    cond_qualifier #(.CW(WIN_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .scl_s     (wires_s[0]),
        .sda_s     (wires_s[1]),
        .win       (ctrl.win),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bus_busy  (bus_busy)
    );

    cond_edge_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (iface_en),
        .scl_s    (wires_s[0]),
        .sda_s    (wires_s[1]),
        .sel_sda  (ctrl.sel_sda),
        .pol_rise (ctrl.pol_rise),
        .clr      (irq_clr),
        .irq_req  (irq_req)
    );
endmodule

// File: rtl/i2c_cond_detector_chk.sv
// Module: i2c_cond_detector_chk
// Temporal checks on the detector's ports, bound into every instance.
module i2c_cond_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       irq_clr,
    input logic       start_det,
    input logic       stop_det,
    input logic       bus_busy,
    input logic       irq_req,
    input logic       cfg_reject
);
    a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_det);
    a_r3_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !stop_det);
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);
    a_r3_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy);
    a_r2_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_clr) |=> irq_req);
    a_r6_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_wdata[4:0] == 5'd0 || reg_wdata[0])) |=> cfg_reject);
endmodule

bind i2c_cond_detector i2c_cond_detector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .irq_clr    (irq_clr),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .bus_busy   (bus_busy),
    .irq_req    (irq_req),
    .cfg_reject (cfg_reject)
);

// File: tb/i2c_cond_detector_tb.sv
`timescale 1ns/1ps
module i2c_cond_detector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       iface_en = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       irq_clr = 1'b0;
    logic       start_det, stop_det, bus_busy, irq_req, cfg_reject;

    int errors = 0;
    int checks = 0;
    int n_start = 0;
    int n_stop = 0;
    bit sparse_tick = 1'b0;
    bit done = 1'b0;
    int cyc = 0;

    always #2 clk = ~clk;

    i2c_cond_detector u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .iface_en(iface_en),
        .scl_in(scl_in), .sda_in(sda_in), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .irq_clr(irq_clr), .start_det(start_det), .stop_det(stop_det),
        .bus_busy(bus_busy), .irq_req(irq_req), .cfg_reject(cfg_reject)
    );

    // pulse counters and sparse tick generator
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (start_det) n_start <= n_start + 1;
        if (stop_det)  n_stop  <= n_stop + 1;
    end
    always @(negedge clk) tick_en <= sparse_tick ? ((cyc % 4) == 0) : 1'b1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_cyc(2);
    endtask

    // SCL low -> set pre level -> SCL high for setup -> SDA move -> hold -> SCL low
    task automatic gen_cond(input bit is_stop, input int setup, input int hold);
        scl_in = 1'b0; wait_cyc(3);
        sda_in = is_stop ? 1'b0 : 1'b1; wait_cyc(3);
        scl_in = 1'b1; wait_cyc(setup);
        sda_in = is_stop ? 1'b1 : 1'b0; wait_cyc(hold);
        scl_in = 1'b0; wait_cyc(6);
    endtask

    task automatic t_reset;
        chk("R1 start_det", start_det, 0);
        chk("R1 stop_det", stop_det, 0);
        chk("R1 bus_busy", bus_busy, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 cfg_reject", cfg_reject, 0);
    endtask

    task automatic t_start_stop;
        int s0, p0;
        wr_reg(8'h04);
        s0 = n_start; p0 = n_stop;
        gen_cond(1'b0, 12, 12);
        chk("R2 one start pulse", n_start - s0, 1);
        chk("R2 no stop pulse", n_stop - p0, 0);
        chk("R2 busy set", bus_busy, 1);
        gen_cond(1'b1, 12, 12);
        chk("R3 one stop pulse", n_stop - p0, 1);
        chk("R3 busy cleared", bus_busy, 0);
    endtask

    task automatic t_short_setup;
        int s0 = n_start;
        gen_cond(1'b0, 1, 12);
        chk("R4 short setup ignored", n_start - s0, 0);
        chk("R4 busy unchanged", bus_busy, 0);
    endtask

    task automatic t_short_hold;
        int s0 = n_start;
        gen_cond(1'b0, 12, 2);
        chk("R5 short hold ignored", n_start - s0, 0);
        chk("R5 busy unchanged", bus_busy, 0);
    endtask

    task automatic t_illegal_cfg;
        int s0;
        wr_reg(8'h1F);
        chk("R6 odd refused", cfg_reject, 1);
        wr_reg(8'h00);
        chk("R6 zero refused", cfg_reject, 1);
        s0 = n_start;
        gen_cond(1'b0, 12, 12);
        chk("R6 window kept at 4", n_start - s0, 1);
        wr_reg(8'h04);
        chk("R6 legal clears flag", cfg_reject, 0);
        gen_cond(1'b1, 12, 12);
        chk("R6 stop restores idle", bus_busy, 0);
    endtask

    task automatic t_tick;
        int s0;
        sparse_tick = 1'b1;
        s0 = n_start;
        gen_cond(1'b0, 10, 10);
        chk("R7 sparse tick stretches setup", n_start - s0, 0);
        gen_cond(1'b0, 30, 30);
        chk("R7 long window passes", n_start - s0, 1);
        gen_cond(1'b1, 30, 30);
        sparse_tick = 1'b0;
        chk("R7 stop under sparse tick", bus_busy, 0);
    endtask

    task automatic t_irq_scl_fall;
        scl_in = 1'b1; wait_cyc(4);
        iface_en = 1'b1; wait_cyc(4);
        chk("R8 no request on enable", irq_req, 0);
        sda_in = 1'b0; wait_cyc(4); sda_in = 1'b1; wait_cyc(4);
        chk("R8 SDA edges ignored", irq_req, 0);
        scl_in = 1'b0; wait_cyc(5);
        chk("R8 SCL fall sets", irq_req, 1);
        wait_cyc(10);
        chk("R10 request sticky", irq_req, 1);
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        wait_cyc(2);
        chk("R10 clear", irq_req, 0);
    endtask

    task automatic t_irq_sda_rise;
        sda_in = 1'b0; wait_cyc(4);
        wr_reg(8'h64);
        chk("R9 no request on select", irq_req, 0);
        sda_in = 1'b1; wait_cyc(5);
        chk("R9 SDA rise sets", irq_req, 1);
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        sda_in = 1'b0; wait_cyc(5);
        chk("R9 SDA fall ignored", irq_req, 0);
    endtask

    task automatic t_irq_enable_reconfig;
        iface_en = 1'b0; wait_cyc(2);
        sda_in = 1'b1; wait_cyc(5);
        chk("R11 disabled edge ignored", irq_req, 0);
        wr_reg(8'h44);
        iface_en = 1'b1; wait_cyc(4);
        chk("R11 enabled, no level match", irq_req, 0);
        wr_reg(8'h64);
        wait_cyc(2);
        chk("R11 polarity change raises request", irq_req, 1);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset;
        t_start_stop;
        t_short_setup;
        t_short_hold;
        t_illegal_cfg;
        t_tick;
        t_irq_scl_fall;
        t_irq_sda_rise;
        t_irq_enable_reconfig;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule